// File: doc/BRIEF.md
# Software-Sequenced Fuse Read Controller

This block lets software read a small one-time-programmable fuse array one byte at a time, with every step of the access driven by hand through a single control word. A plain 32-bit register bus gives access to two registers. The control register holds the mode bits and the fuse address. The data register holds the last byte fetched from the array. The fuse array is a behavioural ROM inside the block, and its contents are computed from parameters.

To read, software puts the array into read mode and writes the wanted address. It then raises the strobe bit, waits for the access delay, reads the data register and lowers the strobe. When it is done it writes the standby code. The array needs time to settle after the strobe edge, so the captured byte appears in the data register a parameterised number of clock cycles after the strobe edge.

Top module: `fuse_rd_ctrl`

## Requirements
- R1: After reset the control register reads 0x0000_0009 (standby) and the data register reads 0x0000_0000.
- R2: A write to byte offset 0x00 stores all 32 bits of `wdata`. A read of offset 0x00 returns exactly the last value written.
- R3: A fetch starts only when a control write raises the strobe (bit 1) from 0 to 1 while the written word has chip-select-bar (bit 0) = 0, load (bit 2) = 1 and program-enable-bar (bit 3) = 1. A strobe that is already high, or any other mode, starts nothing.
- R4: The fetched byte is written into the data register ACCESS_CYC clock edges after the edge that accepts the strobe write. Reads before that edge return the old value.
- R5: The fuse address is the 10-bit field at bits 15:6 of the control word. Fuse location k (k < N_FUSES, default 32) holds (k*29 + 0x53) mod 256.
- R6: If the address is N_FUSES or higher, the fetch loads 0x00.
- R7: The data register keeps its value between fetches. Writes to offset 0x04 are ignored. Reads of any offset other than 0x00 or 0x04, and all reads with `rd_en` low, return 0.
- R8: Once a fetch has started, it completes even if the strobe is lowered or the mode changes. A new valid strobe edge during a fetch restarts the delay with the new address.
- R9: The data register reads as bits 7:0 of offset 0x04, with bits 31:8 always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read enable |
| addr | input | BUS_AW (8) | Byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |

## Verification
Two things can land on the same clock edge: a pending fetch loading the data register, and a new control write. That write may lower the strobe, or it may raise it again to restart the fetch. The random stimulus toggles the strobe and the mode bits densely, so such writes often hit the edge where a countdown expires. A cycle-accurate bench model applies the expiring load before it considers the new write. After every cycle both registers are read back and compared with that model.

// File: rtl/fuse_rd_ctrl.sv
module fuse_rd_ctrl #(
  parameter int unsigned BUS_AW     = 8,
  parameter int unsigned N_FUSES    = 32,
  parameter int unsigned ACCESS_CYC = 3,
  parameter int unsigned FUSE_MUL   = 29,
  parameter int unsigned FUSE_OFS   = 8'h53
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BUS_AW-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata
);
  localparam int unsigned CW = $clog2(ACCESS_CYC + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(ACCESS_CYC);
  localparam logic [CW-1:0] CNT_LAST = CW'(1);
  localparam logic [31:0]   CTRL_RST = 32'h0000_0009;

  function automatic logic [7:0] fuse_byte(input logic [9:0] k);
    int unsigned v;
    v = 32'(k) * FUSE_MUL + FUSE_OFS;
    return (32'(k) < N_FUSES) ? v[7:0] : 8'h00;
  endfunction

  logic [31:0]   ctrl_q;
  logic [7:0]    dout_q;
  logic [9:0]    fa_q;
  logic [CW-1:0] cnt_q;

  wire sel_ctrl = (addr == BUS_AW'(8'h00));
  wire sel_dout = (addr == BUS_AW'(8'h04));
  wire ctrl_wr  = wr_en && sel_ctrl;
  wire rd_mode  = !wdata[0] && wdata[2] && wdata[3];
  wire start    = ctrl_wr && rd_mode && wdata[1] && !ctrl_q[1];
  wire land     = (cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      dout_q <= 8'h00;
      fa_q   <= '0;
      cnt_q  <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= wdata;
      if (land) dout_q <= fuse_byte(fa_q);
      if (start) begin
        fa_q  <= wdata[15:6];
        cnt_q <= CNT_LOAD;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - CNT_LAST;
      end
    end
  end

  assign rdata = !rd_en   ? 32'h0 :
                 sel_ctrl ? ctrl_q :
                 sel_dout ? {24'h0, dout_q} : 32'h0;

  a_r2_ctrl_readback: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> ctrl_q == $past(wdata));
  a_r4_dout_only_on_land: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout_q) |-> $past(cnt_q) == CNT_LAST);
  a_r6_oor_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (land && 32'(fa_q) >= N_FUSES) |=> dout_q == 8'h00);
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == CNT_LOAD && fa_q == $past(wdata[15:6])));
  a_r3_no_start_when_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_q[1] && cnt_q == '0) |=> cnt_q == '0);
  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel_dout) |-> rdata[31:8] == 24'h0);
endmodule

// File: tb/test_fuse_rd_ctrl.sv
module test_fuse_rd_ctrl;
  localparam int PERIOD = 10;
  localparam int K = 3;
  localparam int NF = 32;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;

  fuse_rd_ctrl #(.ACCESS_CYC(K), .N_FUSES(NF)) i_fuse_rd_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata));

  always #(PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_ctrl = 32'h9;
  logic [7:0]  m_dout = 0;
  logic [9:0]  m_addr = 0;
  int          m_cnt = 0;

  function automatic logic [7:0] fv(input logic [9:0] k);
    int v;
    v = int'(k) * 29 + 8'h53;
    return (int'(k) < NF) ? v[7:0] : 8'h00;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    rd_en = 1; addr = a; #1; v = rdata; rd_en = 0; addr = 0;
  endtask

  task automatic step(input bit w, input logic [7:0] a, input logic [31:0] d);
    wr_en = w; addr = a; wdata = d;
    @(posedge clk);
    if (m_cnt != 0) begin
      if (m_cnt == 1) m_dout = fv(m_addr);
      m_cnt--;
    end
    if (w && a == 0) begin
      if (d[1] && !m_ctrl[1] && !d[0] && d[2] && d[3]) begin
        m_cnt = K; m_addr = d[15:6];
      end
      m_ctrl = d;
    end
    @(negedge clk);
    wr_en = 0; addr = 0;
  endtask

  task automatic both(input string req);
    logic [31:0] v;
    rd(8'h00, v); check({req, " ctrl"}, v, m_ctrl);
    rd(8'h04, v); check({req, " dout"}, v, {24'h0, m_dout});
  endtask

  function automatic logic [31:0] cw(input logic [9:0] fa, input logic [3:0] m);
    return {16'h0, fa, 2'b00, m};
  endfunction

  initial begin
    #(PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5eed));
    @(negedge clk); @(negedge clk);
    both("R1 reset");
    rst_n = 1;
    @(negedge clk);
    both("R1 after release");

    step(1, 0, 32'hA5C3_F00F); both("R2 readback");
    step(1, 0, cw(10'd5, 4'b1100)); both("R2 read mode");
    step(1, 0, cw(10'd5, 4'b1110));
    for (int i = 0; i < K - 1; i++) step(0, 0, 0);
    rd(8'h04, v); check("R4 before delay", v, 32'h0);
    step(0, 0, 0);
    rd(8'h04, v); check("R4 R5 after delay", v, {24'h0, fv(10'd5)});
    step(1, 0, cw(10'd5, 4'b1100));

    step(1, 0, cw(10'd31, 4'b1110));
    for (int i = 0; i < K; i++) step(0, 0, 0);
    both("R5 last location");

    step(1, 0, cw(10'd40, 4'b1100));
    step(1, 0, cw(10'd40, 4'b1110));
    for (int i = 0; i < K; i++) step(0, 0, 0);
    rd(8'h04, v); check("R6 out of range", v, 32'h0);

    step(1, 0, cw(10'd7, 4'b1110));
    for (int i = 0; i < K + 1; i++) step(0, 0, 0);
    rd(8'h04, v); check("R3 strobe already high", v, 32'h0);

    step(1, 0, cw(10'd7, 4'b1001));
    step(1, 0, cw(10'd7, 4'b1011));
    for (int i = 0; i < K + 1; i++) step(0, 0, 0);
    rd(8'h04, v); check("R3 standby strobe", v, 32'h0);

    step(1, 0, cw(10'd3, 4'b1100));
    step(1, 0, cw(10'd3, 4'b1110));
    step(1, 0, cw(10'd3, 4'b0001));
    for (int i = 0; i < K; i++) step(0, 0, 0);
    rd(8'h04, v); check("R8 completes after drop", v, {24'h0, fv(10'd3)});

    step(1, 0, cw(10'd9, 4'b1110));
    step(1, 0, cw(10'd9, 4'b1100));
    step(1, 0, cw(10'd12, 4'b1110));
    for (int i = 0; i < K; i++) step(0, 0, 0);
    rd(8'h04, v); check("R8 restart", v, {24'h0, fv(10'd12)});

    step(1, 8'h04, 32'hFFFF_FFFF); both("R7 write 0x04 ignored");
    rd(8'h08, v); check("R7 unmapped read", v, 32'h0);
    rd_en = 0; addr = 8'h00; #1; check("R7 rd_en low", rdata, 32'h0);
    rd(8'h04, v); check("R9 upper bits", {v[31:8], 8'h00}, 32'h0);

    for (int i = 0; i < 600; i++) begin
      logic [31:0] d;
      logic [3:0]  m;
      int r;
      r = $urandom_range(0, 9);
      m = (r < 7) ? {2'b11, 1'($urandom), 1'b0} : 4'($urandom);
      d = {16'($urandom), 10'($urandom_range(0, 40)), 2'($urandom), m};
      if (r == 9) step(1, 8'($urandom_range(0, 2) * 4), d);
      else step($urandom_range(0, 3) != 0, 0, d);
      both("R4 R8 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule